// File: doc/BRIEF.md
# Indirect Table Access Controller

This block lets host software reach a group of internal lookup tables through two registers. A pointer register holds a table-select code, an entry index and an auto-step flag. A data register reads or writes the table and entry that the pointer names. Before each data access, the index is reduced to the depth of the selected table. After each data access, the pointer register is written back. If the auto-step flag is set, the written-back index is advanced and wrapped, so a loop of data accesses walks through a whole table.

Six tables have register storage behind them. Several other select codes are accepted but have no storage: they read as zero and writes to them are dropped, while the pointer still advances. Select codes that are not assigned do nothing and raise an error pulse. Two tables have write side effects. A write to the window-descriptor table sends a re-evaluation pulse that carries the entry index. A write to the interrupt-vector table stores only its server, priority and node fields, and passes the server, minus its two link-pointer bits, and the priority to the interrupt controller.

Top module: `ita_ctrl`

## Requirements
- R1: After reset the pointer register reads 0, every stored table entry reads 0, and err_o, win_evt_o and ivt_upd_o are low.
- R2: A data access uses the entry at (index AND mask), where mask is depth-1 of the selected table. The index is pointer bits [8:0], the select is bits [19:16] and the auto-step flag is bit 63.
- R3: When the auto-step flag is set, each data access with a valid select leaves the pointer index at ((index AND mask)+1) AND mask, so it wraps at the table depth.
- R4: When the auto-step flag is clear, each data access with a valid select writes the pointer index back as (index AND mask). All other pointer bits keep their value.
- R5: Select codes 2,3 (mask 31), 4,9,10 (mask 63), 5 (mask 7) and 6,7 (mask 255) have no storage. A data read of them returns 0, a data write to them is dropped, and the pointer is updated as in R3/R4.
- R6: Select codes 14 and 15 are invalid. A data access with one of them reads 0, changes no table and no pointer bit, and raises err_o for one cycle, one clock after the access.
- R7: Select 11 is the 16-entry window-descriptor table. A data write to it pulses win_evt_o one clock later, with win_idx_o equal to the masked index. Reads of it give no pulse.
- R8: Select 1 is the 8-entry interrupt-vector table. A write to it stores only bits [7:0] (priority), [15:8] (server) and [23:20] (node). All other bits read back as 0.
- R9: A write to the interrupt-vector table pulses ivt_upd_o one clock later, with ivt_idx_o set to the masked index, ivt_server_o set to bits [15:10] of the written data, and ivt_prio_o set to bits [7:0].
- R10: Select 0 (8 entries), 8 (512), 12 (256) and 13 (4) are plain stored tables. A data read returns the entry combinationally, in the same cycle as the access.
- R11: A write to the pointer register (acc_sel=0) stores all 64 bits as given. Reading it back returns them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access this cycle |
| acc_sel | input | 1 | 0 selects the pointer register, 1 the data register |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, valid in the same cycle |
| err_o | output | 1 | Pulse: data access with an invalid select |
| win_evt_o | output | 1 | Pulse: window-descriptor entry written |
| win_idx_o | output | 4 | Index of the window entry that was written |
| ivt_upd_o | output | 1 | Pulse: interrupt-vector entry written |
| ivt_idx_o | output | 3 | Index of the interrupt-vector entry that was written |
| ivt_server_o | output | 6 | Server number with the link bits removed |
| ivt_prio_o | output | 8 | Priority from the interrupt-vector write |

## Verification
The hardest case to reach is the index wrapping inside a table while a side effect also fires. In that case the written-back pointer, the stored entry and the registered pulse must all name the same entry, and they must do so across the wrap point. The stimulus sets the pointer close to the top of the 16-entry window table with auto-step on. It then issues back-to-back data writes, and checks the pointer readback and the pulse index after each one. It then rewinds the pointer and reads the entries back without causing pulses. Unbacked and invalid selects are given indices above their masks, so the wrap arithmetic and the frozen pointer can be told apart.

// File: rtl/ita_pkg.sv
package ita_pkg;

   // Table select codes carried in the pointer register
   typedef enum logic [3:0] {
      TS_LINK = 4'd0,
      TS_IVT  = 4'd1,
      TS_ICAM = 4'd2,
      TS_RBA  = 4'd3,
      TS_RCAM = 4'd4,
      TS_MAP  = 4'd5,
      TS_ESTA = 4'd6,
      TS_ESTB = 4'd7,
      TS_XLAT = 4'd8,
      TS_TCAM = 4'd9,
      TS_TDR  = 4'd10,
      TS_WIN  = 4'd11,
      TS_DOM  = 4'd12,
      TS_PEV  = 4'd13
   } tsel_e;

   // Storage banks behind the backed selects
   typedef enum logic [2:0] {
      BK_LINK = 3'd0,
      BK_IVT  = 3'd1,
      BK_XLAT = 3'd2,
      BK_WIN  = 3'd3,
      BK_DOM  = 3'd4,
      BK_PEV  = 3'd5
   } bank_e;

   localparam int NUM_BANKS = 6;

   // Index masks of selects that have no storage
   localparam int MASK_ICAM = 31;
   localparam int MASK_RBA  = 31;
   localparam int MASK_RCAM = 63;
   localparam int MASK_MAP  = 7;
   localparam int MASK_EST  = 255;
   localparam int MASK_TCAM = 63;
   localparam int MASK_TDR  = 63;
   localparam int MAX_UNBACKED_MASK = 255;

   // Interrupt-vector entry layout
   localparam int IVT_PRIO_LSB = 0;
   localparam int IVT_PRIO_W   = 8;
   localparam int IVT_SRV_LSB  = 8;
   localparam int IVT_SRV_W    = 8;
   localparam int IVT_NODE_LSB = 20;
   localparam int IVT_NODE_W   = 4;
   localparam int IVT_LINK_W   = 2;
   localparam int IVT_SRVO_W   = IVT_SRV_W - IVT_LINK_W;
   localparam int IVT_TOP_BIT  = IVT_NODE_LSB + IVT_NODE_W;

endpackage

// File: rtl/ita_sel_decode.sv
module ita_sel_decode
   import ita_pkg::*;
#(
   parameter int SEL_W      = 4,
   parameter int IDX_W      = 9,
   parameter int LINK_DEPTH = 8,
   parameter int IVT_DEPTH  = 8,
   parameter int XLAT_DEPTH = 512,
   parameter int WIN_DEPTH  = 16,
   parameter int DOM_DEPTH  = 256,
   parameter int PEV_DEPTH  = 4
) (
   input  logic [SEL_W-1:0] sel,
   output logic             ok,
   output logic             backed,
   output bank_e            bank,
   output logic [IDX_W-1:0] mask
);

   logic upper_zero;

   generate
      if (SEL_W > 4) begin : g_wide
         assign upper_zero = (sel[SEL_W-1:4] == '0);
      end else begin : g_narrow
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      ok     = 1'b0;
      backed = 1'b0;
      bank   = BK_LINK;
      mask   = '0;
      if (upper_zero) begin
         case (sel[3:0])
            TS_LINK: begin ok = 1'b1; backed = 1'b1; bank = BK_LINK; mask = IDX_W'(LINK_DEPTH - 1); end
            TS_IVT:  begin ok = 1'b1; backed = 1'b1; bank = BK_IVT;  mask = IDX_W'(IVT_DEPTH - 1);  end
            TS_XLAT: begin ok = 1'b1; backed = 1'b1; bank = BK_XLAT; mask = IDX_W'(XLAT_DEPTH - 1); end
            TS_WIN:  begin ok = 1'b1; backed = 1'b1; bank = BK_WIN;  mask = IDX_W'(WIN_DEPTH - 1);  end
            TS_DOM:  begin ok = 1'b1; backed = 1'b1; bank = BK_DOM;  mask = IDX_W'(DOM_DEPTH - 1);  end
            TS_PEV:  begin ok = 1'b1; backed = 1'b1; bank = BK_PEV;  mask = IDX_W'(PEV_DEPTH - 1);  end
            TS_ICAM: begin ok = 1'b1; mask = IDX_W'(MASK_ICAM); end
            TS_RBA:  begin ok = 1'b1; mask = IDX_W'(MASK_RBA);  end
            TS_RCAM: begin ok = 1'b1; mask = IDX_W'(MASK_RCAM); end
            TS_MAP:  begin ok = 1'b1; mask = IDX_W'(MASK_MAP);  end
            TS_ESTA: begin ok = 1'b1; mask = IDX_W'(MASK_EST);  end
            TS_ESTB: begin ok = 1'b1; mask = IDX_W'(MASK_EST);  end
            TS_TCAM: begin ok = 1'b1; mask = IDX_W'(MASK_TCAM); end
            TS_TDR:  begin ok = 1'b1; mask = IDX_W'(MASK_TDR);  end
            default: begin ok = 1'b0; end
         endcase
      end
   end

endmodule

// File: rtl/ita_reg_bank.sv
module ita_reg_bank #(
   parameter int  DEPTH  = 8,
   parameter int  DATA_W = 64,
   localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= '0;
         end
      end else if (we) begin
         mem_q[idx] <= wdata;
      end
   end

   assign rdata = mem_q[idx];

endmodule

// File: rtl/ita_side_fx.sv
module ita_side_fx
   import ita_pkg::*;
#(
   parameter int WIN_AW = 4,
   parameter int IVT_AW = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  win_we,
   input  logic [WIN_AW-1:0]     win_idx,
   input  logic                  ivt_we,
   input  logic [IVT_AW-1:0]     ivt_idx,
   input  logic [IVT_SRVO_W-1:0] ivt_server,
   input  logic [IVT_PRIO_W-1:0] ivt_prio,
   input  logic                  bad_sel,
   output logic                  err_o,
   output logic                  win_evt_o,
   output logic [WIN_AW-1:0]     win_idx_o,
   output logic                  ivt_upd_o,
   output logic [IVT_AW-1:0]     ivt_idx_o,
   output logic [IVT_SRVO_W-1:0] ivt_server_o,
   output logic [IVT_PRIO_W-1:0] ivt_prio_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_o        <= 1'b0;
         win_evt_o    <= 1'b0;
         win_idx_o    <= '0;
         ivt_upd_o    <= 1'b0;
         ivt_idx_o    <= '0;
         ivt_server_o <= '0;
         ivt_prio_o   <= '0;
      end else begin
         err_o     <= bad_sel;
         win_evt_o <= win_we;
         ivt_upd_o <= ivt_we;
         if (win_we) begin
            win_idx_o <= win_idx;
         end
         if (ivt_we) begin
            ivt_idx_o    <= ivt_idx;
            ivt_server_o <= ivt_server;
            ivt_prio_o   <= ivt_prio;
         end
      end
   end

endmodule

// File: rtl/ita_ctrl.sv
module ita_ctrl
   import ita_pkg::*;
#(
   parameter int  DATA_W     = 64,
   parameter int  IDX_LSB    = 0,
   parameter int  IDX_W      = 9,
   parameter int  SEL_LSB    = 16,
   parameter int  SEL_W      = 4,
   parameter int  AINC_BIT   = 63,
   parameter int  LINK_DEPTH = 8,
   parameter int  IVT_DEPTH  = 8,
   parameter int  XLAT_DEPTH = 512,
   parameter int  WIN_DEPTH  = 16,
   parameter int  DOM_DEPTH  = 256,
   parameter int  PEV_DEPTH  = 4,
   localparam int WIN_AW     = $clog2(WIN_DEPTH),
   localparam int IVT_AW     = $clog2(IVT_DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic                  acc_sel,
   input  logic                  acc_write,
   input  logic [DATA_W-1:0]     acc_wdata,
   output logic [DATA_W-1:0]     acc_rdata,
   output logic                  err_o,
   output logic                  win_evt_o,
   output logic [WIN_AW-1:0]     win_idx_o,
   output logic                  ivt_upd_o,
   output logic [IVT_AW-1:0]     ivt_idx_o,
   output logic [IVT_SRVO_W-1:0] ivt_server_o,
   output logic [IVT_PRIO_W-1:0] ivt_prio_o
);

   // ---------------------------------------------------------------
   // Elaboration-time parameter checks
   // ---------------------------------------------------------------
   function automatic bit is_pow2(int d);
      return (d >= 2) && ((d & (d - 1)) == 0);
   endfunction

   function automatic int bank_depth(int b);
      case (b)
         0:       return LINK_DEPTH;
         1:       return IVT_DEPTH;
         2:       return XLAT_DEPTH;
         3:       return WIN_DEPTH;
         4:       return DOM_DEPTH;
         default: return PEV_DEPTH;
      endcase
   endfunction

   localparam bit FIELDS_FIT = (IDX_LSB + IDX_W <= DATA_W) &&
                               (SEL_LSB + SEL_W <= DATA_W) &&
                               (AINC_BIT < DATA_W);
   localparam bit FIELDS_APART =
      ((IDX_LSB + IDX_W <= SEL_LSB) || (SEL_LSB + SEL_W <= IDX_LSB)) &&
      ((AINC_BIT < IDX_LSB) || (AINC_BIT >= IDX_LSB + IDX_W)) &&
      ((AINC_BIT < SEL_LSB) || (AINC_BIT >= SEL_LSB + SEL_W));

   generate
      if (!FIELDS_FIT) begin : g_chk_fit
         $error("pointer fields do not fit in DATA_W");
      end
      if (!FIELDS_APART) begin : g_chk_apart
         $error("pointer fields overlap");
      end
      if (SEL_W < 4) begin : g_chk_sel
         $error("SEL_W must be at least 4");
      end
      if (DATA_W < IVT_TOP_BIT) begin : g_chk_dw
         $error("DATA_W too narrow for the interrupt-vector layout");
      end
      if ((1 << IDX_W) <= MAX_UNBACKED_MASK) begin : g_chk_idx
         $error("IDX_W too narrow for the unbacked table masks");
      end
      for (genvar c = 0; c < NUM_BANKS; c++) begin : g_chk_depth
         if (!is_pow2(bank_depth(c))) begin : g_bad_pow2
            $error("table depth must be a power of two");
         end
         if (bank_depth(c) > (1 << IDX_W)) begin : g_bad_size
            $error("table depth exceeds index range");
         end
      end
   endgenerate

   localparam logic [DATA_W-1:0] IVT_KEEP =
      (DATA_W'((1 << IVT_PRIO_W) - 1) << IVT_PRIO_LSB) |
      (DATA_W'((1 << IVT_SRV_W)  - 1) << IVT_SRV_LSB)  |
      (DATA_W'((1 << IVT_NODE_W) - 1) << IVT_NODE_LSB);

   // ---------------------------------------------------------------
   // Pointer register and select decode
   // ---------------------------------------------------------------
   logic [DATA_W-1:0]    addr_q;
   logic [IDX_W-1:0]     idx_raw;
   logic [IDX_W-1:0]     idx_m;
   logic [IDX_W-1:0]     idx_next;
   logic [SEL_W-1:0]     sel_raw;
   logic                 ainc;
   logic                 sel_ok;
   logic                 sel_backed;
   bank_e                sel_bank;
   logic [IDX_W-1:0]     sel_mask;
   logic                 data_fire;
   logic                 ok_fire;
   logic                 bad_fire;
   logic                 wr_fire;
   logic [NUM_BANKS-1:0] bank_we;
   logic [DATA_W-1:0]    bank_rd [NUM_BANKS];
   logic [DATA_W-1:0]    table_rd;

   assign idx_raw = addr_q[IDX_LSB +: IDX_W];
   assign sel_raw = addr_q[SEL_LSB +: SEL_W];
   assign ainc    = addr_q[AINC_BIT];

   ita_sel_decode #(
      .SEL_W      (SEL_W),
      .IDX_W      (IDX_W),
      .LINK_DEPTH (LINK_DEPTH),
      .IVT_DEPTH  (IVT_DEPTH),
      .XLAT_DEPTH (XLAT_DEPTH),
      .WIN_DEPTH  (WIN_DEPTH),
      .DOM_DEPTH  (DOM_DEPTH),
      .PEV_DEPTH  (PEV_DEPTH)
   ) u_dec (
      .sel    (sel_raw),
      .ok     (sel_ok),
      .backed (sel_backed),
      .bank   (sel_bank),
      .mask   (sel_mask)
   );

   assign idx_m     = idx_raw & sel_mask;
   assign idx_next  = ainc ? ((idx_m + IDX_W'(1)) & sel_mask) : idx_m;
   assign data_fire = acc_valid && acc_sel;
   assign ok_fire   = data_fire && sel_ok;
   assign bad_fire  = data_fire && !sel_ok;
   assign wr_fire   = ok_fire && acc_write && sel_backed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (acc_valid && !acc_sel && acc_write) begin
         addr_q <= acc_wdata;
      end else if (ok_fire) begin
         addr_q[IDX_LSB +: IDX_W] <= idx_next;
      end
   end

   // ---------------------------------------------------------------
   // Table storage, one bank per backed select
   // ---------------------------------------------------------------
   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam int BD  = bank_depth(b);
         localparam int BAW = $clog2(BD);
         logic [DATA_W-1:0] wd;

         assign bank_we[b] = wr_fire && (sel_bank == bank_e'(b));

         if (b == int'(BK_IVT)) begin : g_ivt_filter
            assign wd = acc_wdata & IVT_KEEP;
         end else begin : g_plain
            assign wd = acc_wdata;
         end

         ita_reg_bank #(
            .DEPTH  (BD),
            .DATA_W (DATA_W)
         ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[b]),
            .idx   (idx_m[BAW-1:0]),
            .wdata (wd),
            .rdata (bank_rd[b])
         );
      end
   endgenerate

   always_comb begin
      table_rd = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (sel_bank == bank_e'(b)) begin
            table_rd = bank_rd[b];
         end
      end
   end

   always_comb begin
      if (!acc_sel) begin
         acc_rdata = addr_q;
      end else if (sel_ok && sel_backed) begin
         acc_rdata = table_rd;
      end else begin
         acc_rdata = '0;
      end
   end

   // ---------------------------------------------------------------
   // Write side effects and error pulse
   // ---------------------------------------------------------------
   ita_side_fx #(
      .WIN_AW (WIN_AW),
      .IVT_AW (IVT_AW)
   ) u_fx (
      .clk          (clk),
      .rst_n        (rst_n),
      .win_we       (bank_we[int'(BK_WIN)]),
      .win_idx      (idx_m[WIN_AW-1:0]),
      .ivt_we       (bank_we[int'(BK_IVT)]),
      .ivt_idx      (idx_m[IVT_AW-1:0]),
      .ivt_server   (acc_wdata[IVT_SRV_LSB + IVT_LINK_W +: IVT_SRVO_W]),
      .ivt_prio     (acc_wdata[IVT_PRIO_LSB +: IVT_PRIO_W]),
      .bad_sel      (bad_fire),
      .err_o        (err_o),
      .win_evt_o    (win_evt_o),
      .win_idx_o    (win_idx_o),
      .ivt_upd_o    (ivt_upd_o),
      .ivt_idx_o    (ivt_idx_o),
      .ivt_server_o (ivt_server_o),
      .ivt_prio_o   (ivt_prio_o)
   );

endmodule

// File: rtl/ita_ctrl_chk.sv
module ita_ctrl_chk
   import ita_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 9,
   parameter int SEL_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_sel,
   input logic              acc_write,
   input logic [DATA_W-1:0] addr_q,
   input logic [IDX_W-1:0]  idx_f,
   input logic [SEL_W-1:0]  sel_f,
   input logic              ainc_f,
   input logic              sel_ok,
   input logic [IDX_W-1:0]  sel_mask,
   input logic              err_o,
   input logic              win_evt_o,
   input logic              ivt_upd_o
);

   AST_BAD_SEL_FREEZES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_sel && !sel_ok) |=> $stable(addr_q)); // R6

   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(acc_valid && acc_sel && !sel_ok)); // R6

   AST_GOOD_SEL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_sel && sel_ok) |=> !err_o); // R6

   AST_AUTO_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_sel && sel_ok && ainc_f) |=>
         (idx_f == IDX_W'((($past(idx_f) & $past(sel_mask)) + IDX_W'(1)) & $past(sel_mask)))); // R3

   AST_HOLD_MASKED_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_sel && sel_ok && !ainc_f) |=>
         (idx_f == ($past(idx_f) & $past(sel_mask)))); // R4

   AST_WIN_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      win_evt_o |-> $past(acc_valid && acc_sel && acc_write && sel_f == SEL_W'(TS_WIN))); // R7

   AST_IVT_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ivt_upd_o |-> $past(acc_valid && acc_sel && acc_write && sel_f == SEL_W'(TS_IVT))); // R9

   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({err_o, win_evt_o, ivt_upd_o}) <= 1); // R6

endmodule

bind ita_ctrl ita_ctrl_chk #(
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W),
   .SEL_W  (SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_sel   (acc_sel),
   .acc_write (acc_write),
   .addr_q    (addr_q),
   .idx_f     (addr_q[IDX_LSB +: IDX_W]),
   .sel_f     (addr_q[SEL_LSB +: SEL_W]),
   .ainc_f    (addr_q[AINC_BIT]),
   .sel_ok    (sel_ok),
   .sel_mask  (sel_mask),
   .err_o     (err_o),
   .win_evt_o (win_evt_o),
   .ivt_upd_o (ivt_upd_o)
);

// File: tb/tb_ita_ctrl.sv
`timescale 1ns/1ps
module tb_ita_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_sel = 1'b0;
   logic        acc_write = 1'b0;
   logic [63:0] acc_wdata = '0;
   logic [63:0] acc_rdata;
   logic        err_o;
   logic        win_evt_o;
   logic [3:0]  win_idx_o;
   logic        ivt_upd_o;
   logic [2:0]  ivt_idx_o;
   logic [5:0]  ivt_server_o;
   logic [7:0]  ivt_prio_o;

   int n_checks = 0;
   int n_fail   = 0;
   logic [63:0] rd;

   always #2.5 clk = ~clk;

   ita_ctrl dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_valid    (acc_valid),
      .acc_sel      (acc_sel),
      .acc_write    (acc_write),
      .acc_wdata    (acc_wdata),
      .acc_rdata    (acc_rdata),
      .err_o        (err_o),
      .win_evt_o    (win_evt_o),
      .win_idx_o    (win_idx_o),
      .ivt_upd_o    (ivt_upd_o),
      .ivt_idx_o    (ivt_idx_o),
      .ivt_server_o (ivt_server_o),
      .ivt_prio_o   (ivt_prio_o)
   );

   function automatic logic [63:0] ptr(input bit ai, input int sel, input int idx);
      return ({63'd0, ai} << 63) | (64'(sel & 15) << 16) | 64'(idx & 511);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
      chk(act === exp, req, act, exp);
   endtask

   // One host access; rdata sampled before the edge, pulses visible after it
   task automatic acc(input bit sel, input bit wr, input logic [63:0] d, output logic [63:0] r);
      @(negedge clk);
      acc_valid = 1'b1;
      acc_sel   = sel;
      acc_write = wr;
      acc_wdata = d;
      #1;
      r = acc_rdata;
      @(posedge clk);
      #1;
      acc_valid = 1'b0;
      acc_write = 1'b0;
   endtask

   task automatic set_ptr(input logic [63:0] p);
      logic [63:0] r;
      acc(1'b0, 1'b1, p, r);
   endtask

   task automatic get_ptr(output logic [63:0] p);
      acc(1'b0, 1'b0, '0, p);
   endtask

   task automatic t_reset;
      logic [63:0] r;
      chk_eq("R1 err low", {63'd0, err_o}, 64'd0);
      chk_eq("R1 win pulse low", {63'd0, win_evt_o}, 64'd0);
      chk_eq("R1 ivt pulse low", {63'd0, ivt_upd_o}, 64'd0);
      get_ptr(r);
      chk_eq("R1 pointer zero", r, 64'd0);
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R1 link entry 0 zero", r, 64'd0);
      set_ptr(ptr(0, 8, 300));
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R1 xlat entry zero", r, 64'd0);
   endtask

   task automatic t_ptr_verbatim;
      logic [63:0] r;
      set_ptr(64'h1234_5678_0009_0005);
      get_ptr(r);
      chk_eq("R11 pointer verbatim", r, 64'h1234_5678_0009_0005);
   endtask

   task automatic t_mask_plain;
      logic [63:0] r;
      set_ptr(ptr(0, 0, 9'h1FD));
      acc(1'b1, 1'b1, 64'hA5A5_0000_1111_2222, r);
      get_ptr(r);
      chk_eq("R4 masked index written back", r, ptr(0, 0, 5));
      set_ptr(ptr(0, 0, 5));
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R10 same-cycle read link 5", r, 64'hA5A5_0000_1111_2222);
      set_ptr(ptr(0, 0, 13));
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R2 index 13 aliases entry 5", r, 64'hA5A5_0000_1111_2222);
      set_ptr(ptr(0, 0, 4));
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R2 neighbour entry untouched", r, 64'd0);
   endtask

   task automatic t_window_wrap;
      logic [63:0] r;
      logic [63:0] v [3];
      int exp_idx [3];
      v[0] = 64'h0E0E_0E0E_0000_0001;
      v[1] = 64'h0F0F_0F0F_0000_0002;
      v[2] = 64'h0000_0000_0000_0003;
      exp_idx[0] = 14; exp_idx[1] = 15; exp_idx[2] = 0;
      set_ptr(ptr(1, 11, 9'h1EE));
      for (int i = 0; i < 3; i++) begin
         acc(1'b1, 1'b1, v[i], r);
         chk_eq("R7 window pulse", {63'd0, win_evt_o}, 64'd1);
         chk_eq("R7 window pulse index", {60'd0, win_idx_o}, 64'(exp_idx[i]));
         get_ptr(r);
         chk_eq("R3 window index after step", r, ptr(1, 11, (exp_idx[i] + 1) & 15));
      end
      set_ptr(ptr(1, 11, 14));
      for (int i = 0; i < 3; i++) begin
         acc(1'b1, 1'b0, '0, r);
         chk_eq("R3 window readback in wrap order", r, v[i]);
         chk_eq("R7 no pulse on read", {63'd0, win_evt_o}, 64'd0);
      end
   endtask

   task automatic t_large_small;
      logic [63:0] r;
      set_ptr(ptr(1, 8, 511));
      acc(1'b1, 1'b1, 64'hDEAD_BEEF_0000_01FF, r);
      get_ptr(r);
      chk_eq("R3 xlat wraps 511 to 0", r, ptr(1, 8, 0));
      set_ptr(ptr(0, 8, 511));
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R10 xlat entry 511", r, 64'hDEAD_BEEF_0000_01FF);
      set_ptr(ptr(0, 13, 7));
      acc(1'b1, 1'b1, 64'h0000_0000_0000_0777, r);
      get_ptr(r);
      chk_eq("R2 event index masked to 3", r, ptr(0, 13, 3));
      set_ptr(ptr(1, 12, 255));
      acc(1'b1, 1'b1, 64'h0000_00FF_0000_0000, r);
      get_ptr(r);
      chk_eq("R3 domain wraps 255 to 0", r, ptr(1, 12, 0));
      set_ptr(ptr(0, 12, 255));
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R10 domain entry 255", r, 64'h0000_00FF_0000_0000);
   endtask

   task automatic t_unbacked;
      logic [63:0] r;
      set_ptr(ptr(1, 6, 9'h1FF));
      acc(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, r);
      chk_eq("R5 unbacked write no error", {63'd0, err_o}, 64'd0);
      get_ptr(r);
      chk_eq("R5 unbacked pointer steps mask 255", r, ptr(1, 6, 0));
      set_ptr(ptr(0, 6, 255));
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R5 unbacked reads zero", r, 64'd0);
      set_ptr(ptr(1, 2, 31));
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R5 unbacked mask 31 read zero", r, 64'd0);
      get_ptr(r);
      chk_eq("R5 mask 31 wraps", r, ptr(1, 2, 0));
      set_ptr(ptr(0, 5, 9'h10F));
      acc(1'b1, 1'b1, 64'h5, r);
      get_ptr(r);
      chk_eq("R5 mask 7 keeps masked index", r, ptr(0, 5, 7));
      set_ptr(ptr(0, 0, 5));
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R5 backed link entry unchanged", r, 64'hA5A5_0000_1111_2222);
   endtask

   task automatic t_invalid;
      logic [63:0] r;
      set_ptr(ptr(1, 14, 3));
      acc(1'b1, 1'b1, 64'h1111_2222_3333_4444, r);
      chk_eq("R6 error pulse on write", {63'd0, err_o}, 64'd1);
      get_ptr(r);
      chk_eq("R6 pointer frozen", r, ptr(1, 14, 3));
      chk_eq("R6 error is one cycle", {63'd0, err_o}, 64'd0);
      set_ptr(ptr(1, 15, 9'h1FF));
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R6 invalid read zero", r, 64'd0);
      chk_eq("R6 error pulse on read", {63'd0, err_o}, 64'd1);
      get_ptr(r);
      chk_eq("R6 pointer frozen on read", r, ptr(1, 15, 9'h1FF));
      set_ptr(ptr(0, 0, 3));
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R6 no table written", r, 64'd0);
      chk_eq("R6 valid select no error", {63'd0, err_o}, 64'd0);
   endtask

   task automatic t_ivt;
      logic [63:0] r;
      set_ptr(ptr(0, 1, 2));
      acc(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, r);
      chk_eq("R9 ivt pulse", {63'd0, ivt_upd_o}, 64'd1);
      chk_eq("R9 ivt index", {61'd0, ivt_idx_o}, 64'd2);
      chk_eq("R9 ivt server shifted", {58'd0, ivt_server_o}, 64'h3F);
      chk_eq("R9 ivt prio", {56'd0, ivt_prio_o}, 64'hFF);
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R8 ivt keeps fields only", r, 64'h0000_0000_00F0_FFFF);
      chk_eq("R9 no pulse on read", {63'd0, ivt_upd_o}, 64'd0);
      set_ptr(ptr(1, 1, 9'h10E));
      acc(1'b1, 1'b1, 64'h7700_0000_00A5_B40C, r);
      chk_eq("R9 ivt index masked", {61'd0, ivt_idx_o}, 64'd6);
      chk_eq("R9 server drops link bits", {58'd0, ivt_server_o}, 64'h2D);
      chk_eq("R9 prio passed", {56'd0, ivt_prio_o}, 64'h0C);
      set_ptr(ptr(0, 1, 6));
      acc(1'b1, 1'b0, '0, r);
      chk_eq("R8 ivt masked readback", r, 64'h0000_0000_00A0_B40C);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      t_reset();
      t_ptr_verbatim();
      t_mask_plain();
      t_window_wrap();
      t_large_small();
      t_unbacked();
      t_invalid();
      t_ivt();
      repeat (2) @(posedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule